// File: doc/BRIEF.md
# Fractional-N Interpolator with Jitter Compensation

This block sequences the digital side of a fractional-N main synthesiser loop. It divides the reference clock by a programmable M and emits a one-clock reference pulse to the phase detector. At each such pulse it adds a fractional numerator F into an accumulator that wraps at a selectable modulus Q of 5 or 8. When that addition overflows, it tells the main divider to use N+1 instead of N for the next cycle.

The accumulator value also drives a pull-up compensation request. This request cancels the phase ripple that comes from alternating between N and N+1. The request is a two-clock window centred on the reference pulse edge. During the window the block drives a proportional magnitude code and, when strobe is high, an integral magnitude code. Analog current DACs downstream turn these codes into current. Every setting arrives as a parallel input.

Top module: `fracn_interp`

## Requirements
- R1: A synchronous reset, while asserted and in the cycle after its release, holds ref_pulse, sel_np1, prop_en and int_en at 0, and holds prop_code and int_code at 0.
- R2: ref_pulse is high for exactly one cycle every M clock cycles. The first pulse is high M cycles after reset is released.
- R3: An m_div value below 3 acts as M = 3.
- R4: prop_en is high for exactly two cycles per reference period. These are the cycle before ref_pulse and the cycle in which ref_pulse is high.
- R5: In the cycle in which ref_pulse is high, the accumulator A becomes (A + F) mod Q. sel_np1 goes high in that same cycle, and stays high until the next ref_pulse, only if that addition reached Q. q_sel8 = 1 selects Q = 8.
- R6: q_sel8 = 0 selects Q = 5. A frac_num value of Q or more acts as Q-1.
- R7: With strobe low, prop_code equals A in both window cycles, and int_en and int_code are 0. Here A is the accumulator value just before the update at that window's reference pulse.
- R8: With strobe high, prop_code in both window cycles equals A·2^(L+1), where L is the 2-bit l_fac.
- R9: With strobe high, int_en is high in both window cycles and int_code equals prop_code·K, where K is the 4-bit k_fac.
- R10: Whenever prop_en is 0, prop_code, int_code and int_en are all 0.
- R11: A new m_div, l_fac or k_fac value is taken at the next reference pulse. The period after that pulse uses the new M, and the windows after that pulse use the new L and K.
- R12: If the modulus selected by q_sel8 differs from the one in use at a reference pulse, the accumulator restarts at the effective F with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| m_div | input | MW (8) | Reference division ratio M |
| q_sel8 | input | 1 | Modulus select: 1 for Q=8, 0 for Q=5 |
| frac_num | input | AW (3) | Fractional numerator F |
| l_fac | input | LW (2) | Strobe-high scaling exponent L |
| k_fac | input | KW (4) | Integral factor K |
| strobe | input | 1 | Selects high-current scaling and the integral pulse |
| ref_pulse | output | 1 | One-cycle reference pulse to the phase detector |
| sel_np1 | output | 1 | Main divider uses N+1 when high |
| prop_en | output | 1 | Proportional compensation window |
| prop_code | output | PW (7) | Proportional compensation magnitude |
| int_en | output | 1 | Integral compensation window |
| int_code | output | IW (11) | Integral compensation magnitude |

## Verification
A wrong accumulator value shows in the next window: prop_code no longer follows the modelled sequence. The matching sel_np1 error shows at the same reference pulse. A divider count or latched M that has gone astray moves ref_pulse or the window within one period. Each period is therefore checked for its length, the position of its two window cycles, and silence outside the window. A stale L or K shadow, or a missed modulus-restart, changes the codes in the first window after the reference pulse at which the change should have taken effect.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
    localparam int M_FLOOR  = 3;
    localparam int Q_LO_DEF = 5;
    localparam int Q_HI_DEF = 8;
endpackage

// File: rtl/fracn_refdiv.sv
module fracn_refdiv #(
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [MW-1:0] m_in,
    output logic          at_edge,
    output logic          win_start,
    output logic          ref_pulse
);
    import fracn_pkg::*;

    typedef struct packed {
        logic [MW-1:0] cnt;
        logic [MW-1:0] mlim;
        logic          refp;
    } state_t;

    state_t        s_d, s_q;
    logic [MW-1:0] m_clamped;

    always_comb begin
        m_clamped = (m_in < MW'(M_FLOOR)) ? MW'(M_FLOOR) : m_in;
        at_edge   = (s_q.cnt == s_q.mlim - MW'(1));
        win_start = (s_q.cnt == s_q.mlim - MW'(2));
        s_d       = s_q;
        s_d.refp  = at_edge;
        if (at_edge) begin
            s_d.cnt  = '0;
            s_d.mlim = m_clamped;
        end else begin
            s_d.cnt  = s_q.cnt + MW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.cnt  <= '0;
            s_q.mlim <= m_clamped;
            s_q.refp <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ref_pulse = s_q.refp;
endmodule

// File: rtl/fracn_accum.sv
module fracn_accum #(
    parameter int Q_LO = 5,
    parameter int Q_HI = 8,
    parameter int AW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          at_edge,
    input  logic          q8_in,
    input  logic [AW-1:0] f_in,
    output logic [AW-1:0] acc,
    output logic          sel_np1
);
    localparam int QW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] acc;
        logic          q8;
        logic          sel;
    } state_t;

    state_t        s_d, s_q;
    logic [QW-1:0] qmod, f_eff, sum;

    always_comb begin
        qmod  = q8_in ? QW'(Q_HI) : QW'(Q_LO);
        f_eff = ({1'b0, f_in} >= qmod) ? (qmod - QW'(1)) : {1'b0, f_in};
        sum   = {1'b0, s_q.acc} + f_eff;
        s_d   = s_q;
        if (at_edge) begin
            s_d.q8 = q8_in;
            if (q8_in != s_q.q8) begin
                s_d.acc = AW'(f_eff);
                s_d.sel = 1'b0;
            end else if (sum >= qmod) begin
                s_d.acc = AW'(sum - qmod);
                s_d.sel = 1'b1;
            end else begin
                s_d.acc = AW'(sum);
                s_d.sel = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.acc <= '0;
            s_q.q8  <= q8_in;
            s_q.sel <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign acc     = s_q.acc;
    assign sel_np1 = s_q.sel;
endmodule

// File: rtl/fracn_compcode.sv
module fracn_compcode #(
    parameter int AW = 3,
    parameter int LW = 2,
    parameter int KW = 4,
    parameter int PW = AW + (1 << LW),
    parameter int IW = PW + KW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          at_edge,
    input  logic          win_start,
    input  logic [AW-1:0] acc,
    input  logic          strobe,
    input  logic [LW-1:0] l_in,
    input  logic [KW-1:0] k_in,
    output logic          prop_en,
    output logic [PW-1:0] prop_code,
    output logic          int_en,
    output logic [IW-1:0] int_code
);
    typedef struct packed {
        logic [LW-1:0] l;
        logic [KW-1:0] k;
        logic          en;
        logic          ien;
        logic [PW-1:0] pc;
        logic [IW-1:0] ic;
    } state_t;

    state_t        s_d, s_q;
    logic [LW:0]   sh;
    logic [PW-1:0] scaled;

    always_comb begin
        sh     = {1'b0, s_q.l} + {{LW{1'b0}}, 1'b1};
        scaled = PW'(acc) << sh;
        s_d    = s_q;
        if (at_edge) begin
            s_d.l = l_in;
            s_d.k = k_in;
        end
        if (win_start) begin
            s_d.en  = 1'b1;
            s_d.ien = strobe;
            s_d.pc  = strobe ? scaled : PW'(acc);
            s_d.ic  = strobe ? (IW'(scaled) * IW'(s_q.k)) : '0;
        end else if (!(at_edge && s_q.en)) begin
            s_d.en  = 1'b0;
            s_d.ien = 1'b0;
            s_d.pc  = '0;
            s_d.ic  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.l   <= l_in;
            s_q.k   <= k_in;
            s_q.en  <= 1'b0;
            s_q.ien <= 1'b0;
            s_q.pc  <= '0;
            s_q.ic  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign prop_en   = s_q.en;
    assign prop_code = s_q.pc;
    assign int_en    = s_q.ien;
    assign int_code  = s_q.ic;
endmodule

// File: rtl/fracn_interp.sv
module fracn_interp #(
    parameter int MW   = 8,
    parameter int Q_LO = fracn_pkg::Q_LO_DEF,
    parameter int Q_HI = fracn_pkg::Q_HI_DEF,
    parameter int LW   = 2,
    parameter int KW   = 4,
    localparam int AW  = $clog2(Q_HI),
    localparam int PW  = AW + (1 << LW),
    localparam int IW  = PW + KW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [MW-1:0] m_div,
    input  logic          q_sel8,
    input  logic [AW-1:0] frac_num,
    input  logic [LW-1:0] l_fac,
    input  logic [KW-1:0] k_fac,
    input  logic          strobe,
    output logic          ref_pulse,
    output logic          sel_np1,
    output logic          prop_en,
    output logic [PW-1:0] prop_code,
    output logic          int_en,
    output logic [IW-1:0] int_code
);
    logic          at_edge;
    logic          win_start;
    logic [AW-1:0] acc;

    fracn_refdiv #(.MW(MW)) u_refdiv (
        .clk      (clk),
        .rst      (rst),
        .m_in     (m_div),
        .at_edge  (at_edge),
        .win_start(win_start),
        .ref_pulse(ref_pulse)
    );

    fracn_accum #(.Q_LO(Q_LO), .Q_HI(Q_HI), .AW(AW)) u_accum (
        .clk    (clk),
        .rst    (rst),
        .at_edge(at_edge),
        .q8_in  (q_sel8),
        .f_in   (frac_num),
        .acc    (acc),
        .sel_np1(sel_np1)
    );

    fracn_compcode #(.AW(AW), .LW(LW), .KW(KW), .PW(PW), .IW(IW)) u_comp (
        .clk      (clk),
        .rst      (rst),
        .at_edge  (at_edge),
        .win_start(win_start),
        .acc      (acc),
        .strobe   (strobe),
        .l_in     (l_fac),
        .k_in     (k_fac),
        .prop_en  (prop_en),
        .prop_code(prop_code),
        .int_en   (int_en),
        .int_code (int_code)
    );
endmodule

// File: rtl/fracn_chk.sv
module fracn_chk #(
    parameter int PW = 7,
    parameter int IW = 11,
    parameter int QH = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ref_pulse,
    input logic          sel_np1,
    input logic          prop_en,
    input logic [PW-1:0] prop_code,
    input logic          int_en,
    input logic [IW-1:0] int_code
);
    a_r2_ref_single: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> !ref_pulse);

    a_r4_ref_in_window: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |-> (prop_en && $past(prop_en)));

    a_r4_window_two: assert property (@(posedge clk) disable iff (rst)
        $rose(prop_en) |=> prop_en);

    a_r4_window_ends: assert property (@(posedge clk) disable iff (rst)
        (prop_en && $past(prop_en)) |=> !prop_en);

    a_r10_quiet_outside: assert property (@(posedge clk) disable iff (rst)
        !prop_en |-> (prop_code == '0 && int_code == '0 && !int_en));

    a_r9_int_in_window: assert property (@(posedge clk) disable iff (rst)
        int_en |-> prop_en);

    a_r7_low_bound: assert property (@(posedge clk) disable iff (rst)
        (prop_en && !int_en) |-> (prop_code < PW'(QH)));

    a_r5_sel_moves_at_ref: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_np1) |-> ref_pulse);
endmodule

bind fracn_interp fracn_chk #(.PW(PW), .IW(IW), .QH(Q_HI)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_pulse(ref_pulse),
    .sel_np1  (sel_np1),
    .prop_en  (prop_en),
    .prop_code(prop_code),
    .int_en   (int_en),
    .int_code (int_code)
);

// File: tb/tb_fracn_interp.sv
`timescale 1ns/1ps
module tb_fracn_interp;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  m_div = 8'd4;
    logic        q_sel8 = 1'b1;
    logic [2:0]  frac_num = 3'd0;
    logic [1:0]  l_fac = 2'd0;
    logic [3:0]  k_fac = 4'd0;
    logic        strobe = 1'b0;
    logic        ref_pulse, sel_np1, prop_en, int_en;
    logic [6:0]  prop_code;
    logic [10:0] int_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int bacc, bq8, bl, bk;

    always #2 clk = ~clk;

    fracn_interp dut (
        .clk(clk), .rst(rst), .m_div(m_div), .q_sel8(q_sel8), .frac_num(frac_num),
        .l_fac(l_fac), .k_fac(k_fac), .strobe(strobe), .ref_pulse(ref_pulse),
        .sel_np1(sel_np1), .prop_en(prop_en), .prop_code(prop_code),
        .int_en(int_en), .int_code(int_code)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic outs_zero(input string tag);
        int v;
        v = int'(ref_pulse) + int'(sel_np1) + int'(prop_en) + int'(int_en)
            + int'(prop_code) + int'(int_code);
        chk(v == 0, tag, v, 0);
    endtask

    task automatic do_reset(input int m, input bit q8, input int f, input int l,
                            input int k, input bit s);
        @(negedge clk);
        rst = 1'b1; m_div = 8'(m); q_sel8 = q8; frac_num = 3'(f);
        l_fac = 2'(l); k_fac = 4'(k); strobe = s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        bacc = 0; bq8 = int'(q8); bl = l; bk = k;
    endtask

    // Advance to the next ref_pulse and check the period against the model.
    task automatic run_period(input int exp_len, input string len_tag,
                              input string sel_tag, input string code_tag);
        int len = 0, pe_cnt = 0, bad = 0;
        int pe_b1 = 0, pc_b1 = 0, ic_b1 = 0, ie_b1 = 0;
        int expA, el, ek, ep, ei, ie, qm, fe, sum, esel;
        bit got = 1'b0;
        while (len < 400) begin
            @(negedge clk);
            len++;
            if (prop_en) pe_cnt++;
            if (!prop_en && (prop_code != 0 || int_code != 0 || int_en)) bad++;
            if (ref_pulse) begin
                got = 1'b1;
                break;
            end
            pe_b1 = int'(prop_en); pc_b1 = int'(prop_code);
            ic_b1 = int'(int_code); ie_b1 = int'(int_en);
        end
        if (!got) begin
            chk(1'b0, "R2", len, exp_len);
            return;
        end
        expA = bacc; el = bl; ek = bk;
        ep = strobe ? (expA << (el + 1)) : expA;
        ei = strobe ? ep * ek : 0;
        ie = int'(strobe);
        qm = q_sel8 ? 8 : 5;
        fe = (int'(frac_num) >= qm) ? qm - 1 : int'(frac_num);
        if (int'(q_sel8) != bq8) begin
            bacc = fe; esel = 0; bq8 = int'(q_sel8);
        end else begin
            sum = bacc + fe;
            if (sum >= qm) begin bacc = sum - qm; esel = 1; end
            else begin bacc = sum; esel = 0; end
        end
        bl = int'(l_fac); bk = int'(k_fac);
        if (exp_len > 0) chk(len == exp_len, len_tag, len, exp_len);
        chk(pe_cnt == 2 && pe_b1 == 1 && prop_en, "R4", pe_cnt, 2);
        chk(bad == 0, "R10", bad, 0);
        chk(int'(prop_code) == ep && pc_b1 == ep, code_tag, int'(prop_code), ep);
        chk(int'(int_code) == ei && ic_b1 == ei, code_tag, int'(int_code), ei);
        chk(int'(int_en) == ie && ie_b1 == ie, code_tag, int'(int_en), ie);
        chk(int'(sel_np1) == esel, sel_tag, int'(sel_np1), esel);
    endtask

    task automatic t_reset;
        do_reset(4, 1'b1, 3, 1, 2, 1'b1);
        outs_zero("R1");
        run_period(4, "R2", "R5", "R8");
        run_period(4, "R2", "R5", "R8");
        rst = 1'b1;
        @(negedge clk);
        outs_zero("R1");
        @(negedge clk);
        outs_zero("R1");
        rst = 1'b0;
        @(negedge clk);
        outs_zero("R1");
        bacc = 0; bq8 = 1; bl = 1; bk = 2;
        run_period(3, "R2", "R5", "R8");
    endtask

    task automatic t_period;
        do_reset(6, 1'b1, 1, 0, 0, 1'b0);
        run_period(6, "R2", "R5", "R7");
        run_period(6, "R2", "R5", "R7");
        do_reset(2, 1'b1, 1, 0, 0, 1'b0);
        run_period(3, "R3", "R5", "R7");
        m_div = 8'd0;
        run_period(3, "R3", "R5", "R7");
        run_period(3, "R3", "R5", "R7");
    endtask

    task automatic t_accum;
        int ones = 0;
        do_reset(5, 1'b1, 3, 0, 0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            run_period(5, "R2", "R5", "R7");
            ones += int'(sel_np1);
        end
        chk(ones == 3, "R5", ones, 3);
    endtask

    task automatic t_mod5;
        do_reset(4, 1'b0, 2, 0, 0, 1'b0);
        for (int i = 0; i < 6; i++) run_period(4, "R2", "R6", "R6");
        frac_num = 3'd6;
        for (int i = 0; i < 6; i++) run_period(4, "R2", "R6", "R6");
    endtask

    task automatic t_codes;
        do_reset(5, 1'b1, 3, 2, 5, 1'b0);
        for (int i = 0; i < 4; i++) run_period(5, "R2", "R5", "R7");
        strobe = 1'b1;
        for (int i = 0; i < 6; i++) run_period(5, "R2", "R5", "R8");
        l_fac = 2'd3; k_fac = 4'd15;
        for (int i = 0; i < 6; i++) run_period(5, "R2", "R5", "R9");
        l_fac = 2'd0; k_fac = 4'd1;
        for (int i = 0; i < 4; i++) run_period(5, "R2", "R5", "R9");
        strobe = 1'b0;
        for (int i = 0; i < 3; i++) run_period(5, "R2", "R5", "R7");
    endtask

    task automatic t_param_timing;
        do_reset(4, 1'b1, 5, 0, 3, 1'b1);
        run_period(4, "R2", "R5", "R8");
        m_div = 8'd7; l_fac = 2'd2; k_fac = 4'd9;
        run_period(4, "R11", "R5", "R11");
        run_period(7, "R11", "R5", "R11");
        run_period(7, "R11", "R5", "R11");
    endtask

    task automatic t_qswitch;
        do_reset(4, 1'b1, 5, 0, 0, 1'b0);
        for (int i = 0; i < 3; i++) run_period(4, "R2", "R5", "R7");
        q_sel8 = 1'b0; frac_num = 3'd2;
        run_period(4, "R2", "R12", "R7");
        run_period(4, "R2", "R12", "R12");
        run_period(4, "R2", "R6", "R12");
        q_sel8 = 1'b1; frac_num = 3'd7;
        run_period(4, "R2", "R12", "R7");
        run_period(4, "R2", "R5", "R12");
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R2 watchdog expired: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_period;
        t_accum;
        t_mod5;
        t_codes;
        t_param_timing;
        t_qswitch;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule